// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Unit

This block holds the interrupt flags for a small multi-channel peripheral DMA controller. Each channel's data mover reports three kinds of event as single-cycle pulses: a transfer finished, half of a transfer finished, or a transfer failed. The block latches every pulse into a sticky flag. All flags are packed into one 32-bit status word, with one 4-bit group per channel.

Software reads the packed word over APB. It acknowledges events by writing a mask to a separate clear register, where a 1 in any bit position drops the matching flag. Each channel drives its own level-sensitive interrupt line. That line is high while any of the channel's flags is set and enabled by the matching enable input. The enable inputs come from per-channel configuration registers that live outside this block.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset every flag is 0, every interrupt line is low and a status read returns 0.
- R2: A high pulse on a channel's done, half or error event input sets that channel's flag at status bit 4*ch+1, 4*ch+2 or 4*ch+3 respectively, at the next clock edge. The flag stays set through idle cycles until it is cleared.
- R3: An APB read at offset 0x0 returns the packed status word with zero wait states. Bit 4*ch of every group always reads 0, and so does every bit belonging to a channel number at or above NUM_CH.
- R4: An APB write at offset 0x4 clears exactly those flags whose bit in the written word is 1 and leaves all others unchanged. A 1 written to bit 4*ch of any group has no effect.
- R5: If an event pulse and a clear of the same flag arrive in the same cycle, the flag is set after that edge.
- R6: irq[ch] is high exactly when at least one of the channel's flags is set with its matching enable (ie_done, ie_half, ie_err) high. It follows enable changes without a clock edge.
- R7: A read at offset 0x4 returns 0. A write at offset 0x0, and any access at another offset, changes no flag; a read at another offset returns 0.
- R8: pready is always high, so every access completes in its first access-phase cycle.
- R9: A clear acts only in the APB access phase (psel and penable both high). A setup phase alone clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and flag clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte offset |
| pwdata | input | 32 | APB write data (clear mask) |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| ev_done | input | NUM_CH | Transfer-complete pulse per channel |
| ev_half | input | NUM_CH | Half-transfer pulse per channel |
| ev_err | input | NUM_CH | Transfer-error pulse per channel |
| ie_done | input | NUM_CH | Complete interrupt enable per channel |
| ie_half | input | NUM_CH | Half interrupt enable per channel |
| ie_err | input | NUM_CH | Error interrupt enable per channel |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
A flag held in the wrong state shows up in two places: the irq line of the affected channel in the same cycle, if that flag's enable is high, and the next status read at 0x0. The bench therefore compares every irq line after every clock edge. It also reads the status word every few cycles, so a lost event, a stray clear or a flag in the wrong group surfaces within about five cycles. Clear writes whose access cycle carries random event pulses catch a wrong priority between set and clear on the edge where it happens.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned GRP_W    = 4;
  localparam int unsigned NUM_KIND = 3;
  localparam int unsigned OFS_STAT = 32'h0;
  localparam int unsigned OFS_CLR  = 32'h4;

  // kind 0 = done, 1 = half, 2 = error
  function automatic int unsigned flag_bit(int unsigned ch, int unsigned kind);
    return GRP_W * ch + 1 + kind;
  endfunction
endpackage

// File: rtl/dma_irq_apb_dec.sv
module dma_irq_apb_dec
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              clr_we,
  output logic              rd_stat,
  output logic              rd_clr
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

  logic access;
  assign access  = psel && penable;
  assign clr_we  = access && pwrite && (paddr == A_CLR);
  assign rd_stat = psel && !pwrite && (paddr == A_STAT);
  assign rd_clr  = psel && !pwrite && (paddr == A_CLR);
endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KIND-1:0] ev,
  input  logic [NUM_KIND-1:0] clr,
  input  logic [NUM_KIND-1:0] ie,
  output logic [NUM_KIND-1:0] flag,
  output logic                irq
);
  logic [NUM_KIND-1:0] flag_q;

  // set has priority over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | ev;
  end

  assign flag = flag_q;
  assign irq  = |(flag_q & ie);

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((flag_q & $past(ev)) == $past(ev)));                  // R2
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev & clr)) |=> ((flag_q & $past(ev & clr)) == $past(ev & clr))); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~ev)) |=> ((flag_q & $past(clr & ~ev)) == '0));         // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0 && clr == '0) |=> $stable(flag_q));                     // R2
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,   // 1 to 8
  parameter int unsigned ADDR_W = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic [NUM_CH-1:0] ev_done,
  input  logic [NUM_CH-1:0] ev_half,
  input  logic [NUM_CH-1:0] ev_err,
  input  logic [NUM_CH-1:0] ie_done,
  input  logic [NUM_CH-1:0] ie_half,
  input  logic [NUM_CH-1:0] ie_err,
  output logic [NUM_CH-1:0] irq
);
  logic clr_we, rd_stat, rd_clr;
  logic [NUM_KIND-1:0] ch_flag [NUM_CH];
  logic [DATA_W-1:0]   stat_word;

  dma_irq_apb_dec #(.ADDR_W(ADDR_W)) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .clr_we  (clr_we),
    .rd_stat (rd_stat),
    .rd_clr  (rd_clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned LO = flag_bit(c, 0);
    logic [NUM_KIND-1:0] clr_c;
    assign clr_c = clr_we ? pwdata[LO +: NUM_KIND] : '0;

    dma_irq_chan u_chan (
      .clk   (pclk),
      .rst_n (presetn),
      .ev    ({ev_err[c], ev_half[c], ev_done[c]}),
      .clr   (clr_c),
      .ie    ({ie_err[c], ie_half[c], ie_done[c]}),
      .flag  (ch_flag[c]),
      .irq   (irq[c])
    );
  end

  always_comb begin
    stat_word = '0;
    for (int unsigned c = 0; c < NUM_CH; c++)
      stat_word[flag_bit(c, 0) +: NUM_KIND] = ch_flag[c];
  end

  assign prdata = rd_stat ? stat_word : '0;
  assign pready = 1'b1;

  AST_PREADY_HIGH: assert property (@(posedge pclk) disable iff (!presetn)
    psel |-> pready);                                  // R8
  AST_CLR_READS_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    rd_clr |-> (prdata == '0));                        // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge pclk) disable iff (!presetn)
    (|irq) |-> (stat_word != '0));                     // R6
  AST_IDLE_BUS_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    !psel |-> (prdata == '0));                         // R3
endmodule

// File: tb/dma_irq_unit_tb.sv
module dma_irq_unit_tb;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready;
  logic [N-1:0] ev_done = 0, ev_half = 0, ev_err = 0;
  logic [N-1:0] ie_done = 0, ie_half = 0, ie_err = 0;
  logic [N-1:0] irq;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] model = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  dma_irq_unit #(.NUM_CH(N), .ADDR_W(8)) u_dut (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .ev_done(ev_done), .ev_half(ev_half), .ev_err(ev_err),
    .ie_done(ie_done), .ie_half(ie_half), .ie_err(ie_err), .irq(irq));

  function automatic logic [31:0] valid_mask();
    logic [31:0] m = 0;
    for (int c = 0; c < N; c++) m[4*c +: 4] = 4'b1110;
    return m;
  endfunction

  function automatic logic [31:0] ev_mask();
    logic [31:0] m = 0;
    for (int c = 0; c < N; c++) begin
      m[4*c+1] = ev_done[c]; m[4*c+2] = ev_half[c]; m[4*c+3] = ev_err[c];
    end
    return m;
  endfunction

  function automatic logic [N-1:0] exp_irq();
    logic [N-1:0] r;
    for (int c = 0; c < N; c++)
      r[c] = (model[4*c+1] & ie_done[c]) | (model[4*c+2] & ie_half[c]) |
             (model[4*c+3] & ie_err[c]);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [31:0] clrm;
    @(posedge clk);
    clrm = (psel && penable && pwrite && paddr == 8'h4) ? pwdata : 32'h0;
    model = ((model & ~clrm) | ev_mask()) & valid_mask();
    @(negedge clk);
  endtask

  task automatic quiet_ev();
    ev_done = 0; ev_half = 0; ev_err = 0;
  endtask

  task automatic apb_read(logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    step();
    penable = 1; #1;
    d = prdata;
    chk("R8 pready", {31'b0, pready}, 32'h1);
    step();
    psel = 0; penable = 0;
  endtask

  task automatic apb_write(logic [7:0] a, logic [31:0] d,
                           logic [N-1:0] ed, logic [N-1:0] eh, logic [N-1:0] ee);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    quiet_ev();
    step();
    penable = 1; ev_done = ed; ev_half = eh; ev_err = ee;
    step();
    psel = 0; penable = 0; pwrite = 0; quiet_ev();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    ie_done = '1; ie_half = '1; ie_err = '1;
    #1 chk("R1 irq after reset", {24'b0, irq}, 32'h0);
    apb_read(8'h0, rd); chk("R1 status after reset", rd, 32'h0);

    // R2 single events in different groups, sticky
    ev_done[0] = 1; ev_half[5] = 1; ev_err[7] = 1;
    step(); quiet_ev();
    repeat (3) step();
    apb_read(8'h0, rd); chk("R2 sticky flags", rd, 32'h8040_0002);
    chk("R2 model agrees", rd, model);

    // R4 bit 0 of every group ignored on clear
    apb_write(8'h4, 32'h1111_1111, 0, 0, 0);
    apb_read(8'h0, rd); chk("R4 bit0 clear ignored", rd, 32'h8040_0002);
    // R9 setup phase alone
    psel = 1; pwrite = 1; paddr = 8'h4; pwdata = 32'hFFFF_FFFF; penable = 0;
    step(); psel = 0; pwrite = 0;
    apb_read(8'h0, rd); chk("R9 setup-only no clear", rd, 32'h8040_0002);
    // R7 write to status offset and stray offset
    apb_write(8'h0, 32'hFFFF_FFFF, 0, 0, 0);
    apb_write(8'h8, 32'hFFFF_FFFF, 0, 0, 0);
    apb_read(8'h0, rd); chk("R7 writes elsewhere ignored", rd, 32'h8040_0002);
    apb_read(8'h4, rd); chk("R7 clear reg reads zero", rd, 32'h0);
    apb_read(8'h8, rd); chk("R7 other offset reads zero", rd, 32'h0);
    // R4 partial clear
    apb_write(8'h4, 32'h0040_0002, 0, 0, 0);
    apb_read(8'h0, rd); chk("R4 partial clear", rd, 32'h8000_0000);

    // R5 event and clear of same bit in same cycle (ch3 done = bit 13)
    apb_write(8'h4, 32'h0000_2000, 8'h08, 0, 0);
    apb_read(8'h0, rd); chk("R5 event beats clear", rd & 32'h2000, 32'h2000);

    // R6 enable follows without a clock
    ie_done = 0; ie_half = 0; ie_err = 0; #1;
    chk("R6 irq all enables off", {24'b0, irq}, 32'h0);
    ie_done[3] = 1; #1;
    chk("R6 irq ch3 done enabled", {24'b0, irq}, 32'h08);
    ie_err[7] = 1; #1;
    chk("R6 irq ch7 err enabled", {24'b0, irq}, 32'h88);
    apb_write(8'h4, 32'hFFFF_FFFF, 0, 0, 0); #1;
    chk("R6 irq drops after clear", {24'b0, irq}, 32'h0);
    apb_read(8'h0, rd); chk("R4 full clear", rd, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      ev_done = N'($urandom & $urandom); ev_half = N'($urandom & $urandom);
      ev_err  = N'($urandom & $urandom & $urandom);
      ie_done = N'($urandom); ie_half = N'($urandom); ie_err = N'($urandom);
      step(); quiet_ev(); #1;
      chk("R6 random irq", {24'b0, irq}, {24'b0, exp_irq()});
      if (i % 5 == 4) begin
        apb_read(8'h0, rd); chk("R3 random status", rd, model);
      end
      if (i % 7 == 3)
        apb_write(8'h4, $urandom, N'($urandom & $urandom), N'($urandom & $urandom),
                  N'($urandom & $urandom));
    end
    apb_read(8'h0, rd); chk("R3 final status", rd & ~valid_mask(), 32'h0);
    chk("R2 final model", rd, model);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule